// File: doc/BRIEF.md
# Bit Alias Address Bridge

This bridge sits between a processor-side request port and a word-wide memory port. Two address windows are reserved as bit aliases. One covers a 32 KB scratch RAM region and the other covers a 1 MB peripheral region. In each alias window, every 32-bit aligned alias word stands for exactly one bit of the backing region.

A read of an alias word fetches the backing word and returns only the selected bit. A write of an alias word performs a locked read-modify-write on the backing word. The write changes only the chosen bit, to the value in bit 0 of the write data. Every other address is forwarded to the memory port unchanged, as a single transfer.

Both ports use the same simple handshake. The requester holds its request, with address, direction and write data stable, until it sees ready high. Read data is valid in the same cycle as ready. On the processor side, the bridge raises ready for exactly one cycle per request. It accepts nothing new until that request has fully completed.

Top module: `bb_alias_bridge`

## Requirements
- R1: While reset is high and right after it falls, cpu_ready and mem_req are both low.
- R2: An access outside both alias windows produces exactly one memory transfer with the same address, direction and write data. A read returns the memory data unchanged. A write returns zero on cpu_rdata.
- R3: An address in 0x2200_0000..0x220F_FFFF with offset K from 0x2200_0000 targets the byte at 0x2000_0000 + (K >> 5), bit K[4:2] of that byte. The memory transfer uses the word-aligned address of that byte.
- R4: An address in 0x4200_0000..0x43FF_FFFF with offset K targets the byte at 0x4000_0000 + (K >> 5), bit K[4:2]. For example, 0x4280_001C selects bit 7 of word 0x4004_0000, and 0x4270_0004 selects bit 1 of word 0x4003_8000.
- R5: An alias write with write data bit 0 equal to 1 sets the target bit and leaves every other bit of the backing word as it was.
- R6: An alias write with write data bit 0 equal to 0 clears the target bit. Write data bits 31..1 have no effect on the stored word.
- R7: An alias read performs one memory read and no write. It returns the target bit in cpu_rdata bit 0, with bits 31..1 zero.
- R8: For an alias write, the write-back to the same word address is issued in the cycle right after the read transfer completes, and mem_req stays high between the two transfers.
- R9: cpu_ready is high for one cycle per request. It only rises after every memory transfer belonging to that request has completed, and never while mem_req is high.
- R10: Byte lanes are little-endian. The byte at address A occupies bits 8*A[1:0]+7 down to 8*A[1:0] of its word, so the target bit index in the word is 8*A[1:0] plus the bit number.
- R11: The memory request, with its address, direction and write data, stays stable while mem_ready is low.
- R12: The last alias word of each window (0x220F_FFFC and 0x43FF_FFFC) is decoded as an alias. Addresses just outside the windows (0x2210_0000, 0x41FF_FFFC and 0x4400_0000) pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read result, valid with cpu_ready |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
The bench builds the bridge with its default parameters. These place both windows at their standard bases, with 15-bit and 20-bit byte-offset fields. With these values, the last alias word of each window and the first word beyond it are reachable with plain test addresses. A bench memory model adds zero to three wait states per transfer, so both the back-to-back read-modify-write and the hold-while-waiting behaviour are exercised. Its scoreboard compares every memory transfer and every processor response against a reference memory kept inside the bench.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int NWIN = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_ARD,
    ST_RMW_RD,
    ST_RMW_WR,
    ST_DONE
  } bb_state_e;
endpackage

// File: rtl/bb_win_dec.sv
// Decodes one alias window: hit, backing word address and bit index in word.
module bb_win_dec #(
  parameter int              AW    = 32,
  parameter int              DW    = 32,
  parameter logic [AW-1:0]   ALIAS = 32'h2200_0000,
  parameter logic [AW-1:0]   BASE  = 32'h2000_0000,
  parameter int              OW    = 15
) (
  input  logic [AW-3:0]          word_sel,
  output logic                   hit,
  output logic [AW-1:0]          word_addr,
  output logic [$clog2(DW)-1:0]  bitpos
);
  localparam int LANE_W = $clog2(DW / 8);
  localparam int TOP_LO = OW + 5;

  logic [AW-1:0] target;

  // Window match on the bits above the alias offset field
  assign hit = (word_sel[AW-3:TOP_LO-2] == ALIAS[AW-1:TOP_LO]);
  // Each byte owns 8 alias words of 4 bytes -> byte offset is offset >> 5
  assign target    = BASE + AW'(word_sel[OW+2:3]);
  assign word_addr = {target[AW-1:LANE_W], {LANE_W{1'b0}}};
  assign bitpos    = {target[LANE_W-1:0], word_sel[2:0]};
endmodule

// File: rtl/bb_bit_op.sv
// Bit merge for the write-back and bit extraction for alias reads.
module bb_bit_op #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]          word,
  input  logic [$clog2(DW)-1:0]  bitpos,
  input  logic                   val,
  output logic [DW-1:0]          merged,
  output logic                   bit_out
);
  always_comb begin
    merged         = word;
    merged[bitpos] = val;
  end

  assign bit_out = word[bitpos];
endmodule

// File: rtl/bb_alias_bridge.sv
module bb_alias_bridge #(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter logic [31:0]   W0_ALIAS = 32'h2200_0000,
  parameter logic [31:0]   W0_BASE  = 32'h2000_0000,
  parameter int            W0_OW    = 15,
  parameter logic [31:0]   W1_ALIAS = 32'h4200_0000,
  parameter logic [31:0]   W1_BASE  = 32'h4000_0000,
  parameter int            W1_OW    = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic           cpu_ready,
  output logic [DW-1:0]  cpu_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ready,
  input  logic [DW-1:0]  mem_rdata
);
  import bb_pkg::*;

  localparam int BIT_W = $clog2(DW);

  logic [NWIN-1:0] hit_v;
  logic [AW-1:0]   waddr_v [NWIN];
  logic [BIT_W-1:0] bpos_v [NWIN];

  generate
    for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
      localparam logic [AW-1:0] G_ALIAS = (gi == 0) ? AW'(W0_ALIAS) : AW'(W1_ALIAS);
      localparam logic [AW-1:0] G_BASE  = (gi == 0) ? AW'(W0_BASE)  : AW'(W1_BASE);
      localparam int            G_OW    = (gi == 0) ? W0_OW : W1_OW;
      bb_win_dec #(
        .AW(AW), .DW(DW), .ALIAS(G_ALIAS), .BASE(G_BASE), .OW(G_OW)
      ) u_dec (
        .word_sel (cpu_addr[AW-1:2]),
        .hit      (hit_v[gi]),
        .word_addr(waddr_v[gi]),
        .bitpos   (bpos_v[gi])
      );
    end
  endgenerate

  // Lowest-numbered window wins if windows were ever configured to overlap
  logic             any_hit;
  logic [AW-1:0]    sel_waddr;
  logic [BIT_W-1:0] sel_bpos;
  always_comb begin
    any_hit   = 1'b0;
    sel_waddr = '0;
    sel_bpos  = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        any_hit   = 1'b1;
        sel_waddr = waddr_v[i];
        sel_bpos  = bpos_v[i];
      end
    end
  end

  bb_state_e        st;
  logic             cur_we;
  logic [BIT_W-1:0] bpos_q;
  logic             setv_q;
  logic [DW-1:0]    merged;
  logic             bit_out;

  bb_bit_op #(.DW(DW)) u_bit (
    .word   (mem_rdata),
    .bitpos (bpos_q),
    .val    (setv_q),
    .merged (merged),
    .bit_out(bit_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cur_we    <= 1'b0;
      bpos_q    <= '0;
      setv_q    <= 1'b0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cpu_req) begin
            cur_we  <= cpu_we;
            bpos_q  <= sel_bpos;
            setv_q  <= cpu_wdata[0];
            mem_req <= 1'b1;
            if (any_hit) begin
              mem_addr  <= sel_waddr;
              mem_we    <= 1'b0;
              mem_wdata <= '0;
              st        <= cpu_we ? ST_RMW_RD : ST_ARD;
            end else begin
              mem_addr  <= cpu_addr;
              mem_we    <= cpu_we;
              mem_wdata <= cpu_wdata;
              st        <= ST_PASS;
            end
          end
        end
        ST_PASS: begin
          if (mem_ready) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_rdata <= cur_we ? '0 : mem_rdata;
            st        <= ST_DONE;
          end
        end
        ST_ARD: begin
          if (mem_ready) begin
            mem_req   <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_rdata <= DW'(bit_out);
            st        <= ST_DONE;
          end
        end
        ST_RMW_RD: begin
          if (mem_ready) begin
            mem_we    <= 1'b1;
            mem_wdata <= merged;
            st        <= ST_RMW_WR;
          end
        end
        ST_RMW_WR: begin
          if (mem_ready) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_rdata <= '0;
            st        <= ST_DONE;
          end
        end
        default: begin
          cpu_ready <= 1'b0;
          st        <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bb_alias_bridge_chk.sv
module bb_alias_bridge_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst,
  input bb_pkg::bb_state_e st,
  input logic              cpu_ready,
  input logic [DW-1:0]     cpu_rdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [DW-1:0]     mem_wdata,
  input logic              mem_ready,
  input logic [DW-1:0]     mem_rdata
);
  import bb_pkg::*;

  logic [DW-1:0] rd_cap;
  always_ff @(posedge clk) begin
    if (rst) rd_cap <= '0;
    else if (st == ST_RMW_RD && mem_req && !mem_we && mem_ready) rd_cap <= mem_rdata;
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R9
  AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !mem_req); // R9
  AST_RMW_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RMW_RD && mem_ready) |=> (mem_req && mem_we)); // R8
  AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RMW_RD && mem_ready) |=> $stable(mem_addr)); // R8
  AST_RMW_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RMW_WR && mem_req) |-> ($countones(mem_wdata ^ rd_cap) <= 1)); // R5
  AST_ALIAS_READ_BIT0: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && $past(st) == ST_ARD) |-> (cpu_rdata[DW-1:1] == '0)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11
  AST_ALIAS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_req && (st == ST_ARD || st == ST_RMW_RD || st == ST_RMW_WR)) |-> (mem_addr[1:0] == 2'b00)); // R3
endmodule

bind bb_alias_bridge bb_alias_bridge_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .st       (st),
  .cpu_ready(cpu_ready),
  .cpu_rdata(cpu_rdata),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ready(mem_ready),
  .mem_rdata(mem_rdata)
);

// File: tb/sim_bb_alias_bridge.sv
module sim_bb_alias_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bb_alias_bridge u0 (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        rmw_first;
    string       tag;
  } mop_t;
  typedef struct {
    logic [31:0] d;
    string       tag;
  } rsp_t;

  mop_t exp_mem[$];
  rsp_t exp_rsp[$];
  logic [31:0] ref_mem[logic [31:0]];
  logic [31:0] mdl_mem[logic [31:0]];
  int total = 0, bad = 0, waits = 0;
  bit finished = 0;

  function automatic logic [31:0] dflt(logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  function automatic logic [31:0] ref_rd(logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : dflt(a);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference decode taken from R3/R4/R10
  function automatic bit alias_map(input logic [31:0] a, output logic [31:0] w, output int b);
    logic [31:0] off, byt;
    w = '0; b = 0;
    if (a >= 32'h2200_0000 && a <= 32'h220F_FFFF) begin
      off = a - 32'h2200_0000; byt = 32'h2000_0000 + (off >> 5);
    end else if (a >= 32'h4200_0000 && a <= 32'h43FF_FFFF) begin
      off = a - 32'h4200_0000; byt = 32'h4000_0000 + (off >> 5);
    end else return 1'b0;
    w = byt & ~32'h3;
    b = int'(byt[1:0]) * 8 + int'(off[4:2]);
    return 1'b1;
  endfunction

  // Driver: pushes expected memory transfers and response, then runs the request
  task automatic access(input logic [31:0] a, input bit we, input logic [31:0] d, input string tag);
    logic [31:0] w, cur, nw;
    int b;
    rsp_t r;
    if (!alias_map(a, w, b)) begin
      exp_mem.push_back('{we, a, d, 1'b0, tag});
      if (we) begin ref_mem[a] = d; r = '{32'h0, tag}; end
      else r = '{ref_rd(a), tag};
    end else if (!we) begin
      cur = ref_rd(w);
      exp_mem.push_back('{1'b0, w, 32'h0, 1'b0, tag});
      r = '{32'(cur[b]), tag};
    end else begin
      cur = ref_rd(w); nw = cur; nw[b] = d[0];
      exp_mem.push_back('{1'b0, w, 32'h0, 1'b1, tag});
      exp_mem.push_back('{1'b1, w, nw, 1'b0, tag});
      ref_mem[w] = nw;
      r = '{32'h0, tag};
    end
    exp_rsp.push_back(r);
    cpu_addr = a; cpu_we = we; cpu_wdata = d; cpu_req = 1'b1;
    do begin @(negedge clk); #1; end while (!cpu_ready);
    cpu_req = 1'b0; cpu_we = 1'b0;
    @(negedge clk); #1;
    chk(!cpu_ready, "R9 ready lasts one cycle", 32'(cpu_ready), 32'h0);
  endtask

  // Memory model and monitor of memory transfers
  int          wcnt = 0;
  logic        last_rmw = 1'b0;
  logic [31:0] last_addr = '0, hold_a = '0;
  logic        hold_we = 1'b0;
  always @(negedge clk) begin
    mop_t m;
    if (rst) begin
      mem_ready = 1'b0; wcnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0; wcnt = 0;
      if (last_rmw) begin
        chk(mem_req && mem_we, "R8 write-back issued next cycle", {30'h0, mem_req, mem_we}, 32'h3);
        chk(mem_addr == last_addr, "R8 write-back same word", mem_addr, last_addr);
        last_rmw = 1'b0;
      end
    end else if (mem_req) begin
      if (wcnt < waits) begin
        if (wcnt == 0) begin hold_a = mem_addr; hold_we = mem_we; end
        else chk(mem_addr == hold_a && mem_we == hold_we, "R11 request stable while waiting", mem_addr, hold_a);
        wcnt++;
      end else begin
        if (exp_mem.size() == 0) chk(1'b0, "R2 unexpected memory transfer", mem_addr, 32'h0);
        else begin
          m = exp_mem.pop_front();
          chk(mem_we == m.we, {m.tag, " direction"}, 32'(mem_we), 32'(m.we));
          chk(mem_addr == m.addr, {m.tag, " address"}, mem_addr, m.addr);
          if (m.we) chk(mem_wdata == m.wdata, {m.tag, " write data"}, mem_wdata, m.wdata);
          last_rmw = m.rmw_first; last_addr = mem_addr;
        end
        if (mem_we) mdl_mem[mem_addr] = mem_wdata;
        else mem_rdata = mdl_mem.exists(mem_addr) ? mdl_mem[mem_addr] : dflt(mem_addr);
        mem_ready = 1'b1;
      end
    end
  end

  // Response monitor
  always @(negedge clk) begin
    rsp_t r;
    if (!rst && cpu_ready) begin
      chk(exp_mem.size() == 0, "R9 response after all memory transfers", exp_mem.size(), 32'h0);
      if (exp_rsp.size() == 0) chk(1'b0, "R9 unexpected response", cpu_rdata, 32'h0);
      else begin
        r = exp_rsp.pop_front();
        chk(cpu_rdata == r.d, {r.tag, " response"}, cpu_rdata, r.d);
      end
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (4) @(negedge clk);
    chk(!cpu_ready && !mem_req, "R1 idle in reset", {30'h0, cpu_ready, mem_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!cpu_ready && !mem_req, "R1 idle after reset", {30'h0, cpu_ready, mem_req}, 32'h0);

    access(32'h2000_0010, 1, 32'h1122_3344, "R2 pass write");
    access(32'h2000_0010, 0, 32'h0, "R2 pass read back");
    access(32'h4000_1234, 0, 32'h0, "R2 pass read default");
    access(32'h2200_0200, 0, 32'h0, "R7 ram alias read bit0");
    access(32'h2200_0208, 0, 32'hFFFF_FFFF, "R7 ram alias read bit2");
    access(32'h2200_0228, 1, 32'h1, "R3 ram alias set byte1 bit2");
    access(32'h2000_0010, 0, 32'h0, "R5 others kept after set");
    access(32'h4280_001C, 1, 32'h1, "R4 peri alias set bit7");
    access(32'h4270_0004, 1, 32'h1, "R4 peri alias set bit1");
    access(32'h4000_0040, 0, 32'h0, "R4 peri word read");
    access(32'h4004_0000, 0, 32'h0, "R5 peri word after set");
    access(32'h4280_001C, 1, 32'hFFFF_FFFE, "R6 clear ignores upper data");
    access(32'h4004_0000, 0, 32'h0, "R6 peri word after clear");
    access(32'h2200_0074, 1, 32'h1, "R10 byte3 bit5 set");
    access(32'h2200_0074, 0, 32'h0, "R10 byte3 bit5 read");
    access(32'h220F_FFFC, 1, 32'h1, "R12 last ram alias");
    access(32'h43FF_FFFC, 0, 32'h0, "R12 last peri alias");
    access(32'h2210_0000, 0, 32'h0, "R12 past ram window");
    access(32'h41FF_FFFC, 0, 32'h0, "R12 below peri window");
    access(32'h4400_0000, 1, 32'hCAFE_0001, "R12 past peri window");

    waits = 3;
    access(32'h2200_0004, 1, 32'h1, "R11 alias write with waits");
    access(32'h2000_0000, 0, 32'h0, "R11 pass read with waits");

    lf = 32'hACE1_2345;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      waits = int'(lf[1:0]) % 3;
      case (lf[5:4])
        2'd0: a = 32'h2200_0000 + {23'h0, lf[14:8], 2'b00};
        2'd1: a = 32'h4200_0000 + {23'h0, lf[14:8], 2'b00};
        2'd2: a = 32'h2000_0000 + {28'h0, lf[9:8], 2'b00};
        default: a = 32'h4000_0000 + {28'h0, lf[9:8], 2'b00};
      endcase
      access(a, lf[16], lf ^ 32'h0F0F_F0F0, "R5 mixed sequence");
    end

    repeat (4) @(negedge clk);
    chk(exp_mem.size() == 0 && exp_rsp.size() == 0, "R9 all expected items consumed",
        exp_mem.size() + exp_rsp.size(), 32'h0);
    finished = 1;
    summary();
    $finish;
  end
endmodule